// File: doc/BRIEF.md
# Video decoder power-up sequencer

This block is a clock-driven controller that brings a video decoder out of power-off in a fixed order. It switches the I/O rail and the core rails on, drives the decoder's active-low power-down and reset pins, and raises a ready flag once configuration traffic on the I2C bus is allowed. It also takes the decoder back down in a safe order, with the pins pulled low before any rail is removed. Two bring-up paths can be chosen when a request starts. The staged path enables the rails one after the other, watches their power-good flags and waits 5 ms at each pin release. The simultaneous path switches everything on in one cycle, asks for a software reset and waits 10 ms once that reset is acknowledged.

Every wait uses one shared millisecond timer. A prescaler turns the clock frequency parameter into a millisecond tick, and a down-counter counts the ticks. The same timer limits how long the controller waits for a power-good flag. If that time runs out, the controller enters a latched fault state, which is left only when the request is withdrawn.

States: `ST_OFF`, `ST_IO_WAIT`, `ST_CORE_WAIT`, `ST_PD_HOLD`, `ST_RST_HOLD`, `ST_READY`, `ST_SIMUL_WAIT`, `ST_SWRST_REQ`, `ST_SWRST_WAIT`, `ST_DRAIN`, `ST_FAULT_PINS`, `ST_FAULT`. The transitions are as follows.

- Staged path: `ST_OFF` goes to `ST_IO_WAIT` when a request arrives with the mode low. When the I/O power-good is seen it goes to `ST_CORE_WAIT`. When all core power-goods are seen it goes to `ST_PD_HOLD`. After the stage wait it goes to `ST_RST_HOLD`, and after a second stage wait it goes to `ST_READY`.
- Simultaneous path: `ST_OFF` goes to `ST_SIMUL_WAIT` when a request arrives with the mode high. When all power-goods are seen it goes to `ST_SWRST_REQ`. When the acknowledge is seen it goes to `ST_SWRST_WAIT`, and after the software-reset wait it goes to `ST_READY`.
- Shutdown: a dropped request, or a lost power-good in any state that needs one, leads to `ST_DRAIN`. From there the next state is always `ST_OFF`.
- Fault: a power-good timeout leads to `ST_FAULT_PINS`, then `ST_FAULT`. The controller returns to `ST_OFF` when the request is low.

Top module: `vdec_pwr_seq`

## Requirements
- R1: While reset is held and in the off state, all rail enables, the software-reset request, ready and fault are 0, and both active-low pins are 0.
- R2: In the staged path (mode input 0), the I/O rail enable rises at the clock edge after the request is sampled high, with the core rails still off. The core rail enables rise only at the edge where the I/O power-good is sampled high.
- R3: In the staged path, the power-down pin goes high at the edge where all core power-goods, and the I/O power-good, are sampled high. No pin rises before that edge.
- R4: The reset pin goes high exactly STAGE_WAIT_MS × (CLK_FREQ_HZ/1000) clock edges after the power-down pin went high.
- R5: In the staged path, ready goes high exactly STAGE_WAIT_MS × (CLK_FREQ_HZ/1000) edges after the reset pin went high.
- R6: In the simultaneous path (mode input 1), all rail enables and both pins go high at the same edge. The software-reset request rises at the edge where all power-goods are sampled high.
- R7: The software-reset request stays high until the acknowledge is sampled high and falls at that edge. Ready rises exactly SOFT_WAIT_MS × (CLK_FREQ_HZ/1000) edges later.
- R8: Ready falls in the same cycle as the request drops or any power-good falls, without waiting for a clock edge.
- R9: On a dropped request or a lost power-good, both pins go low at the next edge with the rails unchanged. All rail enables fall together one edge later.
- R10: If an awaited power-good is not seen within PG_TIMEOUT_MS × (CLK_FREQ_HZ/1000) edges of entering the wait, fault rises and both pins go low at that edge, and every rail enable falls at the next edge. Fault stays high while the request is high and clears at the edge where the request is sampled low.
- R11: The mode input is sampled only at the edge that leaves the off state. Changing it during bring-up does not change the path taken.
- R12: With the request low, the off state holds, and power-good and acknowledge inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| simple_mode_i | input | 1 | Bring-up path: 0 staged, 1 simultaneous |
| pwr_req_i | input | 1 | Power-on request; low powers the decoder down |
| io_pg_i | input | 1 | I/O rail power-good |
| core_pg_i | input | NUM_CORE_RAILS | Core rail power-good flags, one per rail |
| swrst_ack_i | input | 1 | Software-reset acknowledge |
| io_rail_en_o | output | 1 | I/O rail enable |
| core_rail_en_o | output | NUM_CORE_RAILS | Core rail enables |
| pwrdn_n_o | output | 1 | Active-low power-down pin |
| reset_n_o | output | 1 | Active-low reset pin |
| swrst_req_o | output | 1 | Software-reset request |
| bus_ready_o | output | 1 | Configuration bus access permitted |
| fault_o | output | 1 | Power-good timeout fault |

## Verification
The assertions assume that all inputs are synchronous to the clock and change only between edges. They also assume that the acknowledge is a level answer to the request. The properties that reason about rail order read the power-good flags as reports from the rails themselves, so a good flag for a rail that is off would be outside their intent. The stimulus follows this: it changes inputs only on the falling clock edge, raises each power-good only after the matching enable has risen, and drops the flags only when testing a lost rail or after the rails are off.

// File: rtl/vdec_pwr_pkg.sv
package vdec_pwr_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IO_WAIT,
        ST_CORE_WAIT,
        ST_PD_HOLD,
        ST_RST_HOLD,
        ST_READY,
        ST_SIMUL_WAIT,
        ST_SWRST_REQ,
        ST_SWRST_WAIT,
        ST_DRAIN,
        ST_FAULT_PINS,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/vdec_ms_tick.sv
// Millisecond prescaler: tick is high on the last clock of each millisecond.
module vdec_ms_tick #(
    parameter int CYC_PER_MS = 27000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= PRE_TOP;
        end else if (restart_i || (pre_q == '0)) begin
            pre_q <= PRE_TOP;
        end else begin
            pre_q <= pre_q - 1'b1;
        end
    end

    assign tick_o = (pre_q == '0);
endmodule

// File: rtl/vdec_ms_down.sv
// Millisecond down-counter; done is high in the last cycle of the wait.
module vdec_ms_down #(
    parameter int MS_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [MS_W-1:0] load_ms_i,
    input  logic            tick_i,
    output logic            done_o
);
    logic [MS_W-1:0] ms_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ms_q <= '0;
        end else if (load_i) begin
            ms_q <= load_ms_i;
        end else if (tick_i && (ms_q != '0)) begin
            ms_q <= ms_q - 1'b1;
        end
    end

    assign done_o = (ms_q == '0) || ((ms_q == MS_W'(1)) && tick_i);
endmodule

// File: rtl/vdec_pwr_seq.sv
module vdec_pwr_seq
    import vdec_pwr_pkg::*;
#(
    parameter int CLK_FREQ_HZ    = 27_000_000,
    parameter int STAGE_WAIT_MS  = 5,
    parameter int SOFT_WAIT_MS   = 10,
    parameter int PG_TIMEOUT_MS  = 50,
    parameter int NUM_CORE_RAILS = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      simple_mode_i,
    input  logic                      pwr_req_i,
    input  logic                      io_pg_i,
    input  logic [NUM_CORE_RAILS-1:0] core_pg_i,
    input  logic                      swrst_ack_i,
    output logic                      io_rail_en_o,
    output logic [NUM_CORE_RAILS-1:0] core_rail_en_o,
    output logic                      pwrdn_n_o,
    output logic                      reset_n_o,
    output logic                      swrst_req_o,
    output logic                      bus_ready_o,
    output logic                      fault_o
);
    localparam int CYC_RAW    = CLK_FREQ_HZ / 1000;
    localparam int CYC_PER_MS = (CYC_RAW > 0) ? CYC_RAW : 1;
    localparam int MAX_A      = (STAGE_WAIT_MS > SOFT_WAIT_MS) ? STAGE_WAIT_MS : SOFT_WAIT_MS;
    localparam int MAX_MS     = (MAX_A > PG_TIMEOUT_MS) ? MAX_A : PG_TIMEOUT_MS;
    localparam int MS_W       = $clog2(MAX_MS + 1);

    seq_state_e      state_q, state_nx;
    logic            tick, done, load;
    logic [MS_W-1:0] load_ms;
    logic            core_ok, all_ok;
    logic            io_en_q, core_en_q, pd_n_q, rst_n_q, swrst_q, rdy_q, fault_q;

    assign core_ok = &core_pg_i;
    assign all_ok  = io_pg_i && core_ok;

    // Shared wait timer
    vdec_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(load),
        .tick_o   (tick)
    );

    vdec_ms_down #(.MS_W(MS_W)) u_down (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .load_ms_i(load_ms),
        .tick_i   (tick),
        .done_o   (done)
    );

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_req_i) state_nx = simple_mode_i ? ST_SIMUL_WAIT : ST_IO_WAIT;
            end
            ST_IO_WAIT: begin
                if (!pwr_req_i)   state_nx = ST_DRAIN;
                else if (io_pg_i) state_nx = ST_CORE_WAIT;
                else if (done)    state_nx = ST_FAULT_PINS;
            end
            ST_CORE_WAIT: begin
                if (!pwr_req_i || !io_pg_i) state_nx = ST_DRAIN;
                else if (core_ok)           state_nx = ST_PD_HOLD;
                else if (done)              state_nx = ST_FAULT_PINS;
            end
            ST_PD_HOLD: begin
                if (!pwr_req_i || !all_ok) state_nx = ST_DRAIN;
                else if (done)             state_nx = ST_RST_HOLD;
            end
            ST_RST_HOLD: begin
                if (!pwr_req_i || !all_ok) state_nx = ST_DRAIN;
                else if (done)             state_nx = ST_READY;
            end
            ST_READY: begin
                if (!pwr_req_i || !all_ok) state_nx = ST_DRAIN;
            end
            ST_SIMUL_WAIT: begin
                if (!pwr_req_i)  state_nx = ST_DRAIN;
                else if (all_ok) state_nx = ST_SWRST_REQ;
                else if (done)   state_nx = ST_FAULT_PINS;
            end
            ST_SWRST_REQ: begin
                if (!pwr_req_i || !all_ok) state_nx = ST_DRAIN;
                else if (swrst_ack_i)      state_nx = ST_SWRST_WAIT;
            end
            ST_SWRST_WAIT: begin
                if (!pwr_req_i || !all_ok) state_nx = ST_DRAIN;
                else if (done)             state_nx = ST_READY;
            end
            ST_DRAIN:      state_nx = ST_OFF;
            ST_FAULT_PINS: state_nx = ST_FAULT;
            ST_FAULT: begin
                if (!pwr_req_i) state_nx = ST_OFF;
            end
            default:       state_nx = ST_OFF;
        endcase
    end

    // Timer reload on every state change
    assign load = (state_nx != state_q);

    always_comb begin
        unique case (state_nx)
            ST_IO_WAIT, ST_CORE_WAIT, ST_SIMUL_WAIT: load_ms = MS_W'(PG_TIMEOUT_MS);
            ST_PD_HOLD, ST_RST_HOLD:                 load_ms = MS_W'(STAGE_WAIT_MS);
            ST_SWRST_WAIT:                           load_ms = MS_W'(SOFT_WAIT_MS);
            default:                                 load_ms = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_nx;
    end

    // Registered outputs decoded from the state being entered
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            io_en_q   <= 1'b0;
            core_en_q <= 1'b0;
            pd_n_q    <= 1'b0;
            rst_n_q   <= 1'b0;
            swrst_q   <= 1'b0;
            rdy_q     <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            pd_n_q  <= 1'b0;
            rst_n_q <= 1'b0;
            swrst_q <= 1'b0;
            rdy_q   <= 1'b0;
            fault_q <= 1'b0;
            unique case (state_nx)
                ST_OFF: begin
                    io_en_q   <= 1'b0;
                    core_en_q <= 1'b0;
                end
                ST_IO_WAIT: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b0;
                end
                ST_CORE_WAIT: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b1;
                end
                ST_PD_HOLD: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b1;
                    pd_n_q    <= 1'b1;
                end
                ST_RST_HOLD, ST_SIMUL_WAIT, ST_SWRST_WAIT: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b1;
                    pd_n_q    <= 1'b1;
                    rst_n_q   <= 1'b1;
                end
                ST_SWRST_REQ: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b1;
                    pd_n_q    <= 1'b1;
                    rst_n_q   <= 1'b1;
                    swrst_q   <= 1'b1;
                end
                ST_READY: begin
                    io_en_q   <= 1'b1;
                    core_en_q <= 1'b1;
                    pd_n_q    <= 1'b1;
                    rst_n_q   <= 1'b1;
                    rdy_q     <= 1'b1;
                end
                ST_DRAIN: begin
                    // rails hold for one cycle while the pins drop
                end
                ST_FAULT_PINS: begin
                    fault_q <= 1'b1;
                end
                ST_FAULT: begin
                    io_en_q   <= 1'b0;
                    core_en_q <= 1'b0;
                    fault_q   <= 1'b1;
                end
                default: begin
                    io_en_q   <= 1'b0;
                    core_en_q <= 1'b0;
                end
            endcase
        end
    end

    assign io_rail_en_o   = io_en_q;
    assign core_rail_en_o = {NUM_CORE_RAILS{core_en_q}};
    assign pwrdn_n_o      = pd_n_q;
    assign reset_n_o      = rst_n_q;
    assign swrst_req_o    = swrst_q;
    assign fault_o        = fault_q;
    // Ready withdraws in the same cycle as the request or a power-good
    assign bus_ready_o    = rdy_q && pwr_req_i && all_ok;
endmodule

// File: rtl/vdec_pwr_seq_chk.sv
module vdec_pwr_seq_chk #(
    parameter int NUM_CORE_RAILS = 3
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      pwr_req_i,
    input logic                      io_pg_i,
    input logic [NUM_CORE_RAILS-1:0] core_pg_i,
    input logic                      swrst_ack_i,
    input logic                      io_rail_en_o,
    input logic [NUM_CORE_RAILS-1:0] core_rail_en_o,
    input logic                      pwrdn_n_o,
    input logic                      reset_n_o,
    input logic                      swrst_req_o,
    input logic                      bus_ready_o,
    input logic                      fault_o
);
    logic core_en, core_good;
    assign core_en   = core_rail_en_o[0];
    assign core_good = &core_pg_i;

    a_r1_pins_low_before_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(io_rail_en_o) |-> $past(!pwrdn_n_o && !reset_n_o));

    a_r2_core_after_io_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(core_en) && !$rose(io_rail_en_o)) |-> $past(io_pg_i));

    a_r3_pd_after_core_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(pwrdn_n_o) && !$rose(io_rail_en_o)) |-> $past(io_pg_i && core_good));

    a_r4_reset_needs_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_n_o |-> pwrdn_n_o);

    a_r5_ready_all_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_ready_o |-> (pwrdn_n_o && reset_n_o && io_rail_en_o && core_en && !swrst_req_o));

    a_r7_swrst_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swrst_req_o && !swrst_ack_i && pwr_req_i && io_pg_i && core_good) |=> swrst_req_o);

    a_r7_swrst_fall_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(swrst_req_o) && pwrdn_n_o) |-> $past(swrst_ack_i));

    a_r9_pins_drop_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_ready_o) |=> (!pwrdn_n_o && !reset_n_o));

    a_r9_pins_before_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(io_rail_en_o) |-> $past(!pwrdn_n_o && !reset_n_o));

    a_r9_rails_together_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(io_rail_en_o) |-> !core_en);

    a_r9_rails_together_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(core_en) |-> !io_rail_en_o);

    a_r10_fault_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (!pwrdn_n_o && !reset_n_o && !bus_ready_o));

    a_r10_fault_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && pwr_req_i) |=> fault_o);

    a_r10_fault_rails_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && $past(fault_o)) |-> (!io_rail_en_o && !core_en));
endmodule

bind vdec_pwr_seq vdec_pwr_seq_chk #(.NUM_CORE_RAILS(NUM_CORE_RAILS)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_req_i     (pwr_req_i),
    .io_pg_i       (io_pg_i),
    .core_pg_i     (core_pg_i),
    .swrst_ack_i   (swrst_ack_i),
    .io_rail_en_o  (io_rail_en_o),
    .core_rail_en_o(core_rail_en_o),
    .pwrdn_n_o     (pwrdn_n_o),
    .reset_n_o     (reset_n_o),
    .swrst_req_o   (swrst_req_o),
    .bus_ready_o   (bus_ready_o),
    .fault_o       (fault_o)
);

// File: tb/vdec_pwr_seq_bench.sv
`timescale 1ns/1ps
module vdec_pwr_seq_bench;
    localparam int FREQ = 4000;      // 4 clocks per millisecond
    localparam int C    = FREQ / 1000;
    localparam int STG  = 5;
    localparam int SFT  = 10;
    localparam int TMO  = 3;
    localparam int NC   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          simple = 1'b0, req = 1'b0, io_pg = 1'b0, ack = 1'b0;
    logic [NC-1:0] core_pg = '0;
    logic          io_en, pd_n, rs_n, swrst, rdy, flt;
    logic [NC-1:0] core_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vdec_pwr_seq #(
        .CLK_FREQ_HZ(FREQ), .STAGE_WAIT_MS(STG), .SOFT_WAIT_MS(SFT),
        .PG_TIMEOUT_MS(TMO), .NUM_CORE_RAILS(NC)
    ) u_vdec_pwr_seq (
        .clk_i(clk), .rst_ni(rst_n), .simple_mode_i(simple), .pwr_req_i(req),
        .io_pg_i(io_pg), .core_pg_i(core_pg), .swrst_ack_i(ack),
        .io_rail_en_o(io_en), .core_rail_en_o(core_en), .pwrdn_n_o(pd_n),
        .reset_n_o(rs_n), .swrst_req_o(swrst), .bus_ready_o(rdy), .fault_o(flt)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int P_OFF = 0, P_IOW = 1, P_CORW = 2, P_PDW = 3, P_RSTW = 4, P_RDY = 5,
                   P_SIM = 6, P_SWR = 7, P_SWW = 8, P_DOWN = 9, P_FLTP = 10, P_FLT = 11;
    int m_ph = P_OFF;
    int m_left = 0;
    bit m_io = 0, m_core = 0;

    function automatic string tag_of(input int ph);
        case (ph)
            P_OFF:          return "R1";
            P_IOW, P_CORW:  return "R2";
            P_PDW:          return "R3";
            P_RSTW:         return "R4";
            P_RDY:          return "R5";
            P_SIM:          return "R6";
            P_SWR, P_SWW:   return "R7";
            P_DOWN:         return "R9";
            default:        return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        int nxt;
        bit good;
        bit up;
        bit e_pd, e_rs, e_sw, e_rb, e_ft, e_rdy;
        int exp_v, act_v;
        if (!rst_n) begin
            m_ph = P_OFF; m_left = 0; m_io = 0; m_core = 0;
        end else begin
            good = io_pg && (&core_pg);
            up   = (m_left == 1);
            nxt  = m_ph;
            case (m_ph)
                P_OFF:  if (req) nxt = simple ? P_SIM : P_IOW;
                P_IOW:  if (!req) nxt = P_DOWN; else if (io_pg) nxt = P_CORW; else if (up) nxt = P_FLTP;
                P_CORW: if (!req || !io_pg) nxt = P_DOWN; else if (&core_pg) nxt = P_PDW; else if (up) nxt = P_FLTP;
                P_PDW:  if (!req || !good) nxt = P_DOWN; else if (up) nxt = P_RSTW;
                P_RSTW: if (!req || !good) nxt = P_DOWN; else if (up) nxt = P_RDY;
                P_RDY:  if (!req || !good) nxt = P_DOWN;
                P_SIM:  if (!req) nxt = P_DOWN; else if (good) nxt = P_SWR; else if (up) nxt = P_FLTP;
                P_SWR:  if (!req || !good) nxt = P_DOWN; else if (ack) nxt = P_SWW;
                P_SWW:  if (!req || !good) nxt = P_DOWN; else if (up) nxt = P_RDY;
                P_DOWN: nxt = P_OFF;
                P_FLTP: nxt = P_FLT;
                default: if (!req) nxt = P_OFF;
            endcase
            if (nxt != m_ph) begin
                case (nxt)
                    P_IOW, P_CORW, P_SIM: m_left = TMO * C;
                    P_PDW, P_RSTW:        m_left = STG * C;
                    P_SWW:                m_left = SFT * C;
                    default:              m_left = 0;
                endcase
            end else if (m_left > 0) begin
                m_left--;
            end
            m_ph = nxt;
            case (nxt)
                P_OFF, P_FLT:    begin m_io = 0; m_core = 0; end
                P_IOW:           begin m_io = 1; m_core = 0; end
                P_DOWN, P_FLTP:  ;
                default:         begin m_io = 1; m_core = 1; end
            endcase
        end
        #1;
        e_pd  = (m_ph inside {P_PDW, P_RSTW, P_RDY, P_SIM, P_SWR, P_SWW});
        e_rs  = (m_ph inside {P_RSTW, P_RDY, P_SIM, P_SWR, P_SWW});
        e_sw  = (m_ph == P_SWR);
        e_rb  = (m_ph == P_RDY);
        e_ft  = (m_ph inside {P_FLTP, P_FLT});
        e_rdy = e_rb && req && io_pg && (&core_pg);
        check("R8", int'(rdy), int'(e_rdy), "ready vs model");
        exp_v = {m_io, {NC{m_core}}, e_pd, e_rs, e_sw, e_ft};
        act_v = {io_en, core_en, pd_n, rs_n, swrst, flt};
        check(tag_of(m_ph), exp_v, act_v == exp_v ? exp_v : act_v, "outputs vs model");
    end

    function automatic logic sel_sig(input int sel);
        case (sel)
            0:       return rs_n;
            1:       return rdy;
            2:       return flt;
            default: return io_en;
        endcase
    endfunction

    task automatic count_until(input int sel, output int n);
        n = 0;
        while (!sel_sig(sel) && n < 2000) begin
            @(posedge clk); #2;
            n++;
        end
    endtask

    task automatic at_edge();
        @(posedge clk); #2;
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        at_edge();
        check("R1", {io_en, core_en, pd_n, rs_n, swrst, rdy, flt}, 0, "outputs after reset");

        // R12: request low, other inputs wiggle
        @(negedge clk); io_pg = 1'b1; core_pg = '1; ack = 1'b1;
        repeat (6) at_edge();
        check("R12", {io_en, core_en, pd_n, rs_n, swrst, rdy, flt}, 0, "off with request low");
        @(negedge clk); io_pg = 1'b0; core_pg = '0; ack = 1'b0;

        // Staged path
        @(negedge clk); simple = 1'b0; req = 1'b1;
        at_edge();
        check("R2", {io_en, core_en, pd_n, rs_n}, {1'b1, {NC{1'b0}}, 2'b00}, "io rail first");
        @(negedge clk); simple = 1'b1;            // R11: ignored mid bring-up
        at_edge();
        check("R2", int'(core_en), 0, "core waits for io power-good");
        @(negedge clk); io_pg = 1'b1;
        at_edge();
        check("R2", int'(core_en), (1 << NC) - 1, "core rails after io power-good");
        check("R3", int'(pd_n), 0, "pd pin low before core power-good");
        @(negedge clk); core_pg = '1;
        at_edge();
        check("R3", int'(pd_n), 1, "pd pin released on core power-good");
        check("R11", int'(rs_n), 0, "staged path kept after mode change");
        count_until(0, n);
        check("R4", n, STG * C, "edges from pd release to reset release");
        check("R11", int'(swrst), 0, "no software reset in staged path");
        count_until(1, n);
        check("R5", n, STG * C, "edges from reset release to ready");
        repeat (4) at_edge();

        // R8 / R9: request withdrawn
        @(negedge clk); req = 1'b0;
        #1;
        check("R8", int'(rdy), 0, "ready drops with request");
        at_edge();
        check("R9", {pd_n, rs_n, io_en, core_en}, {2'b00, 1'b1, {NC{1'b1}}}, "pins low, rails held");
        at_edge();
        check("R9", {io_en, core_en}, 0, "rails dropped together");
        @(negedge clk); io_pg = 1'b0; core_pg = '0;

        // Simultaneous path
        repeat (3) @(negedge clk);
        req = 1'b1;
        at_edge();
        check("R6", {io_en, core_en, pd_n, rs_n}, {1'b1, {NC{1'b1}}, 2'b11}, "everything released together");
        check("R6", int'(swrst), 0, "no software reset before power-good");
        @(negedge clk); io_pg = 1'b1; core_pg = '1;
        at_edge();
        check("R6", int'(swrst), 1, "software reset requested");
        repeat (5) at_edge();
        check("R7", int'(swrst), 1, "request held without acknowledge");
        @(negedge clk); ack = 1'b1;
        at_edge();
        check("R7", int'(swrst), 0, "request drops on acknowledge");
        @(negedge clk); ack = 1'b0;
        count_until(1, n);
        check("R7", n, SFT * C, "edges from acknowledge to ready");
        repeat (3) at_edge();

        // R8 / R9: one core power-good lost
        @(negedge clk); core_pg = 3'b101;
        #1;
        check("R8", int'(rdy), 0, "ready drops with power-good");
        at_edge();
        check("R9", {pd_n, rs_n, io_en}, 3'b001, "pins low first after power-good loss");
        at_edge();
        check("R9", {io_en, core_en}, 0, "rails off after power-good loss");
        @(negedge clk); req = 1'b0; io_pg = 1'b0; core_pg = '0;
        repeat (3) at_edge();

        // R10: staged path timeout
        @(negedge clk); simple = 1'b0; req = 1'b1;
        count_until(3, n);
        count_until(2, n);
        check("R10", n, TMO * C, "edges from io enable to fault");
        check("R10", {pd_n, rs_n, io_en}, 3'b001, "pins low, rail held at fault");
        at_edge();
        check("R10", {io_en, core_en}, 0, "rails off in fault");
        repeat (5) at_edge();
        check("R10", int'(flt), 1, "fault latched while requested");
        @(negedge clk); req = 1'b0;
        at_edge();
        check("R10", int'(flt), 0, "fault cleared by request low");

        // R10: simultaneous path timeout
        @(negedge clk); simple = 1'b1; req = 1'b1;
        count_until(3, n);
        count_until(2, n);
        check("R10", n, TMO * C, "edges to fault in simultaneous path");
        @(negedge clk); req = 1'b0;
        repeat (4) at_edge();
        check("R1", {io_en, core_en, pd_n, rs_n, swrst, rdy, flt}, 0, "back to off");
        finish_up();
    end
endmodule